// File: doc/BRIEF.md
# Word-wide XOR accumulation harvester

This block turns a serial stream of random bits into 32-bit output words. Incoming bits are packed into words. Each finished word is then combined with a running 32-bit accumulator by a whole-word XOR, so every bit is mixed with the bit that arrived 32 positions earlier rather than with its immediate neighbour. The accumulator is written to an output FIFO only after a programmable minimum number of words has been folded into it. This trades output rate for quality: with a minimum of n folds, a free-running FIFO receives one word per n raw words. While the FIFO reports full, folding goes on, so slow reading raises the effective fold count.

A 32-bit configuration word, written through a data/write-enable pair, sets the minimum fold count. It also switches on an optional pair-based debiasing stage in front of the packer and carries a 15-bit field that is passed on unchanged to the external entropy source. A fold count of zero selects raw bypass: each packed word replaces the accumulator instead of being XORed into it. The configuration stays in force until the next write.

Top module: `wordFoldHarvester`

## Requirements
- R1: After reset, outWe is low, srcCfg is zero, the fold count is zero, the debias stage is off and the accumulator holds zero.
- R2: Bits sampled while bitValid is high are packed first-to-last into bit 0 upward. A cycle with bitValid low adds nothing. The 32nd accepted bit completes a word, which is folded on the following clock edge.
- R3: With a fold count n of 1 to 15, every completed word is XORed as a whole into the accumulator, and a push presents the accumulator value on outData.
- R4: After a push, or after a configuration write, the next push happens only once at least max(n,1) words have been folded since that event. The push is then signalled as outWe in the cycle after the fold that met the count.
- R5: With n = 0, each completed word replaces the accumulator, so every push carries the most recent packed word.
- R6: outWe is never high while outFull is high. Completed words keep being folded during that time, and the pending word is pushed once outFull drops.
- R7: A push does not clear the accumulator. The next word is XORed onto the value just delivered, so with n = 1 each output is the XOR of all words folded since reset.
- R8: With the debias bit set, accepted bits are taken in pairs. A pair of 0 then 1 yields a 0, a pair of 1 then 0 yields a 1, and equal pairs yield nothing. Only the yielded bits reach the packer, and a configuration write restarts pairing.
- R9: The configuration word is captured on paramWe. The fold count is bits 3..0, the debias enable is bit 4 and srcCfg is bits 19..5. Bits 31..20 are reserved and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Serial random bit |
| bitValid | input | 1 | bitIn is valid this cycle |
| paramData | input | 32 | Configuration word |
| paramWe | input | 1 | Capture paramData this cycle |
| outFull | input | 1 | Output FIFO cannot accept a word |
| outData | output | 32 | Word presented to the output FIFO |
| outWe | output | 1 | Write strobe to the output FIFO |
| srcCfg | output | 15 | Timing and selection field forwarded to the entropy source |

## Verification
The properties assume that outFull is a plain level from the consumer and that configuration writes are single-cycle strobes that may land at any time. They also assume that a completed word can follow another no sooner than 32 accepted bits later, which the packer guarantees whatever bitValid does. The stimulus drives bits from a deterministic shift-register sequence with periodic idle gaps. It holds outFull high for several whole words, and it issues configuration writes only after a few quiet cycles, so that no pair or word straddles a change of mode. A fixed alternating pair pattern yields a known debiased word whose output value can be predicted exactly.

// File: rtl/harvestPkg.sv
`timescale 1ns/1ps
package harvestPkg;
  // configuration word layout
  localparam int PARAM_W  = 32;
  localparam int FOLD_LSB = 0;
  localparam int FOLD_W   = 4;
  localparam int VN_BIT   = 4;
  localparam int SRC_LSB  = 5;
  localparam int SRC_W    = 15;
  localparam int RES_LSB  = SRC_LSB + SRC_W;

  // strobes from control to datapath
  typedef struct packed {
    logic fold;       // fold the completed raw word this cycle
    logic bypass;     // replace instead of XOR (fold count zero)
    logic clearPair;  // restart debias pairing
  } strobe_t;
endpackage

// File: rtl/vnFilter.sv
`timescale 1ns/1ps
module vnFilter (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic clearPair,
  input  logic bitIn,
  input  logic bitValid,
  output logic outBit,
  output logic outValid
);
  logic haveHeld;
  logic heldBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveHeld <= 1'b0;
      heldBit  <= 1'b0;
    end else if (clearPair || !enable) begin
      haveHeld <= 1'b0;
    end else if (bitValid) begin
      if (haveHeld) begin
        haveHeld <= 1'b0;
      end else begin
        haveHeld <= 1'b1;
        heldBit  <= bitIn;
      end
    end
  end

  always_comb begin
    if (enable) begin
      outBit   = heldBit;
      outValid = bitValid && haveHeld && (heldBit != bitIn) && !clearPair;
    end else begin
      outBit   = bitIn;
      outValid = bitValid;
    end
  end
endmodule

// File: rtl/wordPacker.sv
`timescale 1ns/1ps
module wordPacker #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inBit,
  input  logic              inValid,
  output logic [WORD_W-1:0] word,
  output logic              wordValid
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     bitCount;
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount  <= '0;
      shiftReg  <= '0;
      word      <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (inValid) begin
        if (bitCount == LAST) begin
          word      <= {inBit, shiftReg[WORD_W-1:1]};
          wordValid <= 1'b1;
          bitCount  <= '0;
        end else begin
          shiftReg <= {inBit, shiftReg[WORD_W-1:1]};
          bitCount <= bitCount + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/harvestDatapath.sv
`timescale 1ns/1ps
module harvestDatapath
  import harvestPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic              vnEnable,
  input  strobe_t           strobe,
  output logic [WORD_W-1:0] rawWord,
  output logic              rawValid,
  output logic [WORD_W-1:0] accWord
);
  logic filtBit;
  logic filtValid;

  vnFilter uVn (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (vnEnable),
    .clearPair(strobe.clearPair),
    .bitIn    (bitIn),
    .bitValid (bitValid),
    .outBit   (filtBit),
    .outValid (filtValid)
  );

  wordPacker #(.WORD_W(WORD_W)) uPack (
    .clk      (clk),
    .rstN     (rstN),
    .inBit    (filtBit),
    .inValid  (filtValid),
    .word     (rawWord),
    .wordValid(rawValid)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accWord <= '0;
    end else if (strobe.fold) begin
      accWord <= strobe.bypass ? rawWord : (accWord ^ rawWord);
    end
  end
endmodule

// File: rtl/harvestCtrl.sv
`timescale 1ns/1ps
module harvestCtrl
  import harvestPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PARAM_W-1:0] paramData,
  input  logic               paramWe,
  input  logic               rawValid,
  input  logic               outFull,
  output strobe_t            strobe,
  output logic               outWe,
  output logic               vnEnable,
  output logic [SRC_W-1:0]   srcCfg,
  output logic [FOLD_W-1:0]  foldN
);
  logic [FOLD_W-1:0] foldsLeft;
  logic              wordReady;
  logic              push;
  logic [FOLD_W-1:0] cntBase;
  logic [FOLD_W-1:0] cntDec;
  logic              unusedReserved;

  assign unusedReserved = ^paramData[PARAM_W-1:RES_LSB];

  assign push    = wordReady && !outFull;
  assign outWe   = push;
  assign cntBase = push ? foldN : foldsLeft;
  assign cntDec  = (cntBase == '0) ? '0 : cntBase - 1'b1;

  always_comb begin
    strobe.fold      = rawValid;
    strobe.bypass    = (foldN == '0);
    strobe.clearPair = paramWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      foldN     <= '0;
      vnEnable  <= 1'b0;
      srcCfg    <= '0;
      foldsLeft <= '0;
      wordReady <= 1'b0;
    end else if (paramWe) begin
      foldN     <= paramData[FOLD_LSB +: FOLD_W];
      vnEnable  <= paramData[VN_BIT];
      srcCfg    <= paramData[SRC_LSB +: SRC_W];
      foldsLeft <= paramData[FOLD_LSB +: FOLD_W];
      wordReady <= 1'b0;
    end else if (rawValid) begin
      foldsLeft <= cntDec;
      wordReady <= (cntDec == '0);
    end else if (push) begin
      foldsLeft <= foldN;
      wordReady <= 1'b0;
    end
  end
endmodule

// File: rtl/wordFoldHarvester.sv
`timescale 1ns/1ps
module wordFoldHarvester
  import harvestPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic [31:0]       paramData,
  input  logic              paramWe,
  input  logic              outFull,
  output logic [WORD_W-1:0] outData,
  output logic              outWe,
  output logic [14:0]       srcCfg
);
  strobe_t           strobe;
  logic              vnEnable;
  logic [FOLD_W-1:0] foldN;
  logic [WORD_W-1:0] rawWord;
  logic              rawValid;
  logic [WORD_W-1:0] accWord;

  harvestCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .paramData(paramData),
    .paramWe  (paramWe),
    .rawValid (rawValid),
    .outFull  (outFull),
    .strobe   (strobe),
    .outWe    (outWe),
    .vnEnable (vnEnable),
    .srcCfg   (srcCfg),
    .foldN    (foldN)
  );

  harvestDatapath #(.WORD_W(WORD_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .bitIn   (bitIn),
    .bitValid(bitValid),
    .vnEnable(vnEnable),
    .strobe  (strobe),
    .rawWord (rawWord),
    .rawValid(rawValid),
    .accWord (accWord)
  );

  assign outData = accWord;
endmodule

// File: rtl/harvestChecker.sv
`timescale 1ns/1ps
module harvestChecker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              outFull,
  input logic              outWe,
  input logic              paramWe,
  input logic [3:0]        foldN,
  input logic              rawValid,
  input logic [WORD_W-1:0] rawWord,
  input logic [WORD_W-1:0] accWord
);
  // R6: nothing is written while the FIFO is full
  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    outFull |-> !outWe);

  // R4: with two or more folds required, pushes cannot be adjacent
  a_r4_min_gap: assert property (@(posedge clk) disable iff (!rstN)
    (outWe && foldN > 4'd1) |=> !outWe);

  // R5: raw bypass copies the packed word into the accumulator
  a_r5_raw_copy: assert property (@(posedge clk) disable iff (!rstN)
    (rawValid && foldN == 4'd0) |=> (accWord == $past(rawWord)));

  // R3: whole-word XOR fold
  a_r3_xor_fold: assert property (@(posedge clk) disable iff (!rstN)
    (rawValid && foldN != 4'd0) |=> (accWord == ($past(accWord) ^ $past(rawWord))));

  // R7: the accumulator only moves on a fold, never on a push
  a_r7_acc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rawValid |=> $stable(accWord));

  // R2: a completed word is a single-cycle event
  a_r2_word_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rawValid |=> !rawValid);
endmodule

bind wordFoldHarvester harvestChecker #(.WORD_W(WORD_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .outFull (outFull),
  .outWe   (outWe),
  .paramWe (paramWe),
  .foldN   (foldN),
  .rawValid(rawValid),
  .rawWord (rawWord),
  .accWord (accWord)
);

// File: tb/wordFoldHarvester_test.sv
`timescale 1ns/1ps
module wordFoldHarvester_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitIn = 1'b0;
  logic        bitValid = 1'b0;
  logic [31:0] paramData = '0;
  logic        paramWe = 1'b0;
  logic        outFull = 1'b0;
  logic [31:0] outData;
  logic        outWe;
  logic [14:0] srcCfg;

  always #4 clk = ~clk;

  wordFoldHarvester uut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .paramData(paramData), .paramWe(paramWe), .outFull(outFull),
    .outData(outData), .outWe(outWe), .srcCfg(srcCfg)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference model state
  int          mFoldN = 0;
  bit          mVn = 0;
  int          mFolds = 0;
  logic [31:0] mAcc = '0;
  bit          mHave = 0;
  bit          mHeld = 0;
  bit          mBits[$];
  bit          mRawValid = 0;
  logic [31:0] mRawWord = '0;
  int          pushCount = 0;
  logic [31:0] lastPush = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit nextBit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic step(input logic vld, input logic b, input logic pwe,
                      input logic [31:0] pd, input logic full);
    bit expWe;
    bit emit;
    bit eb;
    int need;
    @(negedge clk);
    bitValid = vld; bitIn = b; paramWe = pwe; paramData = pd; outFull = full;
    #2;
    need  = (mFoldN == 0) ? 1 : mFoldN;
    expWe = (mFolds >= need) && !full;
    check(outWe === expWe, curReq, "outWe", {31'd0, outWe}, {31'd0, expWe});
    if (expWe && outWe === 1'b1)
      check(outData === mAcc, curReq, "outData", outData, mAcc);
    if (outWe === 1'b1) begin
      pushCount++;
      lastPush = outData;
    end
    // advance the model across the coming edge
    emit = 0; eb = 0;
    if (mVn) begin
      if (pwe) mHave = 0;
      else if (vld) begin
        if (mHave) begin
          if (mHeld != b) begin emit = 1; eb = mHeld; end
          mHave = 0;
        end else begin
          mHave = 1; mHeld = b;
        end
      end
    end else begin
      mHave = 0; emit = vld; eb = b;
    end
    if (mRawValid) mAcc = (mFoldN == 0) ? mRawWord : (mAcc ^ mRawWord);
    if (pwe) begin
      mFoldN = int'(pd[3:0]); mVn = pd[4]; mFolds = 0;
    end else begin
      if (expWe) mFolds = 0;
      if (mRawValid && mFolds < 1000) mFolds++;
    end
    mRawValid = 0;
    if (emit) begin
      mBits.push_back(eb);
      if (mBits.size() == 32) begin
        for (int i = 0; i < 32; i++) mRawWord[i] = mBits[i];
        mBits.delete();
        mRawValid = 1;
      end
    end
  endtask

  task automatic idle(input int n, input logic full);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, full);
  endtask

  task automatic writeParam(input logic [31:0] pd);
    idle(3, 0);
    step(0, 0, 1, pd, 0);
  endtask

  task automatic sendWords(input int n, input logic full);
    for (int w = 0; w < n; w++)
      for (int i = 0; i < 32; i++) begin
        if (i % 7 == 3) step(0, 0, 0, '0, full);
        step(1, nextBit(), 0, '0, full);
      end
  endtask

  initial begin
    int base;
    logic [31:0] accBefore;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outWe === 1'b0, "R1", "outWe after reset", {31'd0, outWe}, 32'd0);
    check(srcCfg === 15'd0, "R1", "srcCfg after reset", {17'd0, srcCfg}, 32'd0);

    // R1/R7: scrambler mode starting from a zero accumulator
    curReq = "R7";
    writeParam(32'h0000_0001);
    base = pushCount;
    sendWords(3, 0); idle(4, 0);
    check(pushCount - base == 3, "R7", "pushes at n=1", pushCount - base, 3);

    // R2/R5: raw bypass
    curReq = "R5";
    writeParam(32'h0000_0000);
    base = pushCount;
    sendWords(4, 0); idle(4, 0);
    check(pushCount - base == 4, "R5", "pushes at n=0", pushCount - base, 4);

    // R3/R4: minimum fold counts
    curReq = "R4";
    writeParam(32'h0000_0002);
    base = pushCount;
    sendWords(8, 0); idle(4, 0);
    check(pushCount - base == 4, "R4", "pushes at n=2", pushCount - base, 4);
    curReq = "R3";
    writeParam(32'h0000_000F);
    base = pushCount;
    sendWords(14, 0); idle(4, 0);
    check(pushCount - base == 0, "R4", "no push before 15 folds", pushCount - base, 0);
    sendWords(1, 0); idle(4, 0);
    check(pushCount - base == 1, "R3", "push after 15 folds", pushCount - base, 1);

    // R6: FIFO full, folding continues
    curReq = "R6";
    writeParam(32'h0000_0003);
    base = pushCount;
    sendWords(6, 1); idle(4, 1);
    check(pushCount - base == 0, "R6", "no push while full", pushCount - base, 0);
    idle(4, 0);
    check(pushCount - base == 1, "R6", "pending push after release", pushCount - base, 1);
    sendWords(3, 0); idle(4, 0);
    check(pushCount - base == 2, "R6", "pushes after release", pushCount - base, 2);

    // R8: debias stage with a known pair pattern
    curReq = "R8";
    writeParam(32'h0000_0011);
    base = pushCount;
    accBefore = mAcc;
    for (int p = 0; p < 64; p++) begin
      case (p % 4)
        0: begin step(1, 0, 0, '0, 0); step(1, 1, 0, '0, 0); end
        1: begin step(1, 1, 0, '0, 0); step(1, 0, 0, '0, 0); end
        2: begin step(1, 0, 0, '0, 0); step(1, 0, 0, '0, 0); end
        default: begin step(1, 1, 0, '0, 0); step(1, 1, 0, '0, 0); end
      endcase
    end
    idle(4, 0);
    check(pushCount - base == 1, "R8", "debiased word count", pushCount - base, 1);
    check(lastPush === (accBefore ^ 32'hAAAA_AAAA), "R8", "debiased word",
          lastPush, accBefore ^ 32'hAAAA_AAAA);
    for (int i = 0; i < 300; i++) step(1, nextBit(), 0, '0, 0);
    idle(4, 0);

    // R9: field capture, reserved bits ignored
    curReq = "R9";
    writeParam({12'hFFF, 15'h2D5A, 1'b0, 4'h1});
    idle(1, 0);
    check(srcCfg === 15'h2D5A, "R9", "srcCfg field", {17'd0, srcCfg}, 32'h2D5A);
    base = pushCount;
    sendWords(2, 0); idle(4, 0);
    check(pushCount - base == 2, "R9", "pushes with reserved bits set", pushCount - base, 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog %s actual=timeout expected=completion", curReq);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule